// File: doc/BRIEF.md
# Receive-Path Input Gain Limiter

This block sits on the far-end receive path of a voice processor and handles one signed 16-bit linear sample per 8 kHz frame. It keeps a running mean-square estimate of the incoming level. It scales each sample by a gain factor chosen from that estimate, so that loud far-end speech cannot drive the local loop into howling. Quiet material passes untouched. Material between a lower threshold and a knee is pulled down toward the threshold level in fixed dB steps. Anything at or above the knee takes one fixed maximum cut.

Limiting is switched by a request level. The request is taken only on the first clock after reset is released and on a falling edge of the frame interrupt. Between those events the request is ignored. A device strapped as a cascade slave never limits. All level constants are squared amplitudes computed at elaboration from a reference RMS that defines 0 dBm0, so the hardware needs no logarithm.

Top module: `gl_rx_limiter`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_sample` are 0, the level estimate is cleared and limiting is off.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `out_sample` changes only then.
- R3: On every valid sample x, the estimate L is updated as L + floor((x² − L) / 2^SMOOTH_SHIFT). The gain for sample x is chosen from L as it stood before that update.
- R4: When limiting is on and L is below the squared −10 dBm0 level (REF_RMS² · 0.1), the gain is unity.
- R5: With limiting on and the estimate between the −10 dBm0 and −1.5 dBm0 squared levels, n counts the step thresholds at or below L. The thresholds lie at −10 + 0.5·i dBm0 for i = 0..16. The attenuation is 0.5·(n − 1) dB, coded as round(32768 · 10^(−att/20)).
- R6: When limiting is on and L is at or above the −1.5 dBm0 squared level, the attenuation is a fixed 8.5 dB, whatever the input amplitude.
- R7: The limit request is captured on the first clock after reset release and on any clock where `frame_irq` was high on the previous clock and is low now. At all other times, changes of the request have no effect.
- R8: While `cascade_slave` is high, every valid sample passes with unity gain, whatever the captured request.
- R9: With limiting off, each output sample equals its input sample exactly, one cycle later.
- R10: The output is (x · g + 2^14) >> 15 with an arithmetic shift (round half up), saturated to the signed 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| limit_req | input | 1 | Limiting request level, 1 = limit |
| frame_irq | input | 1 | Frame interrupt; its falling edge captures the request |
| cascade_slave | input | 1 | Strap: 1 = cascade slave, limiting forced off |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed scaled sample |

## Verification
The bench sweeps square waves from well below the threshold to near full scale, so that the estimate settles inside every band and above the knee. A wrong comparator or table entry would show up as a misplaced dB step. A gain that keeps falling past the knee would fail the fixed-cut check. A single loud sample after silence must pass unscaled, which catches an estimate that is updated before the gain is chosen. The request is changed on a rising frame edge and with no edge at all, which exposes a latch that is transparent or that triggers on the wrong edge. Sample gaps, the slave strap and a −32768 input cover a lost strobe, an ignored strap, and rounding or saturation errors.

// File: rtl/gl_pkg.sv
package gl_pkg;

   // Squared amplitude of the level (floor_db + step_db*idx) dBm0 for a given 0 dBm0 RMS
   function automatic longint level_thr(input int idx, input int ref_rms,
                                        input real floor_db, input real step_db);
      real p;
      p = real'(ref_rms) * real'(ref_rms) * (10.0 ** ((floor_db + step_db * idx) / 10.0));
      return longint'(p);
   endfunction

   // Gain code for band k: 0 = unity, 1..nstep = stepped cut, beyond = maximum cut
   function automatic longint gain_code(input int k, input int nstep, input real step_db,
                                        input real max_db, input int frac);
      real att;
      real g;
      if (k == 0)          att = 0.0;
      else if (k <= nstep) att = step_db * (k - 1);
      else                 att = max_db;
      g = (2.0 ** frac) * (10.0 ** (-att / 20.0));
      return longint'(g);
   endfunction

endpackage

// File: rtl/gl_enable_latch.sv
module gl_enable_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic limit_req,
   input  logic frame_irq,
   input  logic cascade_slave,
   output logic gain_on
);
   logic armed_q;
   logic irq_q;
   logic req_q;
   logic capture;

   assign capture = !armed_q || (irq_q && !frame_irq);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         irq_q   <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         armed_q <= 1'b1;
         irq_q   <= frame_irq;
         if (capture) req_q <= limit_req;
      end
   end

   assign gain_on = req_q && !cascade_slave;

   // R7: a request level changes only at a captured event
   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !$fell(frame_irq)) |=> $stable(req_q));

endmodule

// File: rtl/gl_level_est.sv
module gl_level_est #(
   parameter int DATA_W = 16,
   parameter int SHIFT  = 5,
   parameter int LVL_W  = 2 * DATA_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   output logic [LVL_W-1:0]         level
);
   localparam int SW = LVL_W + 1;
   localparam logic [LVL_W-1:0] MAX_SQ = LVL_W'(64'(1) << (2 * DATA_W - 2));

   logic signed [2*DATA_W-1:0] prod;
   logic [LVL_W-1:0]           sq;
   logic [LVL_W-1:0]           lvl_q;
   logic [LVL_W-1:0]           lvl_next;

   assign prod = in_sample * in_sample;
   assign sq   = LVL_W'($unsigned(prod));

   generate
      if (SHIFT == 0) begin : g_instant
         assign lvl_next = sq;
      end else begin : g_smooth
         logic signed [SW-1:0] diff;
         logic signed [SW-1:0] step;
         logic signed [SW-1:0] sum;
         assign diff     = $signed({1'b0, sq}) - $signed({1'b0, lvl_q});
         assign step     = diff >>> SHIFT;
         assign sum      = $signed({1'b0, lvl_q}) + step;
         assign lvl_next = sum[LVL_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lvl_q <= '0;
      else if (in_valid) lvl_q <= lvl_next;
   end

   assign level = lvl_q;

   // R3: the smoothed estimate stays within the largest possible square
   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= MAX_SQ);

endmodule

// File: rtl/gl_gain_select.sv
module gl_gain_select #(
   parameter int  LVL_W     = 32,
   parameter int  GAIN_W    = 16,
   parameter int  GAIN_FRAC = 15,
   parameter int  NSTEP     = 17,
   parameter int  REF_RMS   = 16000,
   parameter real FLOOR_DB  = -10.0,
   parameter real KNEE_DB   = -1.5
) (
   input  logic [LVL_W-1:0]  level,
   input  logic              gain_on,
   output logic [GAIN_W-1:0] gain
);
   localparam int  NTHR    = NSTEP + 1;
   localparam int  IDX_W   = $clog2(NTHR + 1);
   localparam real SPAN_DB = KNEE_DB - FLOOR_DB;
   localparam real STEP_DB = SPAN_DB / NSTEP;

   logic [NTHR-1:0]   hit;
   logic [GAIN_W-1:0] tab [NTHR+1];
   logic [IDX_W-1:0]  idx;

   for (genvar i = 0; i < NTHR; i++) begin : g_cmp
      localparam longint T = gl_pkg::level_thr(i, REF_RMS, FLOOR_DB, STEP_DB);
      assign hit[i] = (64'(level) >= 64'(T));
   end

   for (genvar k = 0; k <= NTHR; k++) begin : g_tab
      localparam longint G = gl_pkg::gain_code(k, NSTEP, STEP_DB, SPAN_DB, GAIN_FRAC);
      assign tab[k] = GAIN_W'(G);
   end

   assign idx  = IDX_W'($countones(hit));
   assign gain = gain_on ? tab[idx] : tab[0];

   // R5: ascending thresholds must fire as a thermometer code
   always_comb begin
      if (!$isunknown(hit))
         assert_thermo_R5: assert (((hit + 1'b1) & hit) == '0);
   end

   // R6: no chosen gain is below the maximum cut
   always_comb begin
      if (!$isunknown(gain))
         assert_floor_gain_R6: assert (gain >= tab[NTHR]);
   end

endmodule

// File: rtl/gl_scaler.sv
module gl_scaler #(
   parameter int DATA_W    = 16,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   input  logic [GAIN_W-1:0]        gain,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_sample
);
   localparam int PW = DATA_W + GAIN_W + 1;
   localparam logic signed [PW-1:0] HALF  = PW'(64'(1) << (GAIN_FRAC - 1));
   localparam logic signed [PW-1:0] MAXV  = PW'((64'(1) << (DATA_W - 1)) - 1);
   localparam logic signed [PW-1:0] MINV  = -MAXV - PW'(1);
   localparam logic [GAIN_W-1:0]    UNITY = GAIN_W'(64'(1) << GAIN_FRAC);

   logic signed [PW-1:0]     prod;
   logic signed [PW-1:0]     shifted;
   logic signed [DATA_W-1:0] sat;

   assign prod    = PW'(in_sample) * PW'($signed({1'b0, gain}));
   assign shifted = (prod + HALF) >>> GAIN_FRAC;

   always_comb begin
      if (shifted > MAXV)      sat = MAXV[DATA_W-1:0];
      else if (shifted < MINV) sat = MINV[DATA_W-1:0];
      else                     sat = shifted[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= sat;
      end
   end

   assert_strobe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_strobe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_sample)));
   assert_unity_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && gain == UNITY) |=> (out_sample == $past(in_sample)));

endmodule

// File: rtl/gl_rx_limiter.sv
module gl_rx_limiter #(
   parameter int  DATA_W       = 16,
   parameter int  REF_RMS      = 16000,
   parameter int  SMOOTH_SHIFT = 5,
   parameter int  NSTEP        = 17,
   parameter int  GAIN_FRAC    = 15,
   parameter real FLOOR_DB     = -10.0,
   parameter real KNEE_DB      = -1.5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_sample,
   input  logic                     limit_req,
   input  logic                     frame_irq,
   input  logic                     cascade_slave,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_sample
);
   localparam int GAIN_W = GAIN_FRAC + 1;
   localparam int LVL_W  = 2 * DATA_W;

   if (DATA_W < 4 || DATA_W > 24) begin : g_bad_width
      $error("gl_rx_limiter: DATA_W out of range");
   end
   if (SMOOTH_SHIFT < 0 || SMOOTH_SHIFT > LVL_W - 2) begin : g_bad_shift
      $error("gl_rx_limiter: SMOOTH_SHIFT out of range");
   end
   if (NSTEP < 1 || NSTEP > 64) begin : g_bad_steps
      $error("gl_rx_limiter: NSTEP out of range");
   end
   if (GAIN_FRAC < 2 || GAIN_FRAC > 30) begin : g_bad_frac
      $error("gl_rx_limiter: GAIN_FRAC out of range");
   end
   if (REF_RMS < 1 || REF_RMS >= (1 << (DATA_W - 1))) begin : g_bad_ref
      $error("gl_rx_limiter: REF_RMS out of range");
   end
   if (!(KNEE_DB > FLOOR_DB)) begin : g_bad_knee
      $error("gl_rx_limiter: knee must lie above the threshold");
   end

   logic              gain_on;
   logic [LVL_W-1:0]  level;
   logic [GAIN_W-1:0] gain;

   gl_enable_latch u_latch (
      .clk           (clk),
      .rst_n         (rst_n),
      .limit_req     (limit_req),
      .frame_irq     (frame_irq),
      .cascade_slave (cascade_slave),
      .gain_on       (gain_on)
   );

   gl_level_est #(.DATA_W(DATA_W), .SHIFT(SMOOTH_SHIFT), .LVL_W(LVL_W)) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .level     (level)
   );

   gl_gain_select #(
      .LVL_W(LVL_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .NSTEP(NSTEP),
      .REF_RMS(REF_RMS), .FLOOR_DB(FLOOR_DB), .KNEE_DB(KNEE_DB)
   ) u_gain (
      .level   (level),
      .gain_on (gain_on),
      .gain    (gain)
   );

   gl_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_scale (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .gain       (gain),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   // R8: a slave passes samples through untouched
   assert_slave_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade_slave && in_valid) |=> (out_sample == $past(in_sample)));

endmodule

// File: tb/gl_rx_limiter_tb.sv
`timescale 1ns/1ps
module gl_rx_limiter_tb;
   localparam int REF = 16000;
   localparam int SH  = 5;
   localparam int NS  = 17;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, in_valid = 1'b0, limit_req = 1'b0, frame_irq = 1'b0, cascade_slave = 1'b0;
   logic signed [15:0] in_sample = '0;
   wire out_valid;
   wire signed [15:0] out_sample;

   gl_rx_limiter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .limit_req(limit_req), .frame_irq(frame_irq), .cascade_slave(cascade_slave),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   int checks = 0;
   int fails  = 0;
   longint thr [NS+1];
   longint gtab [NS+2];
   string  ph = "";

   initial begin
      for (int i = 0; i <= NS; i++)
         thr[i] = longint'(real'(REF) * real'(REF) * $pow(10.0, (-10.0 + 0.5 * i) / 10.0));
      gtab[0] = 32768;
      for (int k = 1; k <= NS; k++)
         gtab[k] = longint'(32768.0 * $pow(10.0, -(0.5 * (k - 1)) / 20.0));
      gtab[NS+1] = longint'(32768.0 * $pow(10.0, -8.5 / 20.0));
   end

   // behavioural reference
   longint m_ms = 0, m_out = 0, g, p, r, sq;
   bit     m_gc = 0, m_armed = 0, m_fq = 0, m_ov = 0, en;
   int     idx;
   string  m_tag = "R1";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ms = 0; m_out = 0; m_gc = 0; m_armed = 0; m_fq = 0; m_ov = 0;
      end else begin
         if (in_valid) begin
            idx = 0;
            for (int i = 0; i <= NS; i++) if (m_ms >= thr[i]) idx++;
            en = m_gc && !cascade_slave;
            g  = en ? gtab[idx] : gtab[0];
            p  = longint'(in_sample) * g;
            r  = (p + 16384) >>> 15;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            m_out = r;
            m_ov  = 1;
            if (ph != "")        m_tag = ph;
            else if (!en)        m_tag = cascade_slave ? "R8" : "R9";
            else if (idx == 0)   m_tag = "R4";
            else if (idx > NS)   m_tag = "R6";
            else                 m_tag = "R5";
            sq   = longint'(in_sample) * longint'(in_sample);
            m_ms = m_ms + ((sq - m_ms) >>> SH);
         end else begin
            m_ov = 0;
         end
         if (!m_armed || (m_fq && !frame_irq)) m_gc = limit_req;
         m_armed = 1;
         m_fq    = frame_irq;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_cycle();
      chk(out_valid === m_ov, "R2", longint'(out_valid), longint'(m_ov));
      if (m_ov) chk(out_sample == m_out, m_tag, longint'(out_sample), m_out);
   endtask

   // square wave of amplitude amp; every gap-th slot idle when gap > 0
   task automatic drive(input int n, input int amp, input int gap);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check_cycle();
         in_valid  = (gap == 0) || (k % gap != 0);
         in_sample = 16'((k % 2) ? amp : -amp - 1);
      end
   endtask

   task automatic one(input int val, input string tag, input longint exp);
      @(negedge clk);
      check_cycle();
      in_valid  = 1'b1;
      in_sample = 16'(val);
      @(negedge clk);
      check_cycle();
      chk(out_sample == exp, tag, longint'(out_sample), exp);
      in_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      limit_req = 1'b1;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
         chk(out_sample == 0, "R1", longint'(out_sample), 0);
      end
      rst_n = 1'b1;
      drive(60, 1000, 0);                       // quiet: R4
      one(30000, "R3", 30000);                  // estimate lags: unity on first loud sample
      drive(40, 1000, 0);
      foreach (thr[i]) begin end
      drive(150, 2000, 3);
      drive(150, 5200, 3);                      // just above threshold: R5
      drive(150, 7000, 3);
      drive(150, 9000, 0);
      drive(150, 11000, 3);
      drive(150, 13000, 0);
      drive(150, 16000, 3);                     // above knee: R6
      drive(150, 30000, 0);
      ph = "R10";
      drive(120, 32767, 0);                     // reaches -32768
      drive(60, 12345, 0);
      ph = "R7";
      limit_req = 1'b0;                         // no event: ignored
      drive(60, 20000, 0);
      frame_irq = 1'b1;                         // rising edge: ignored
      drive(60, 20000, 2);
      ph = "";
      frame_irq = 1'b0;                         // falling edge: limiting off
      drive(80, 25000, 0);
      one(30001, "R9", 30001);
      limit_req = 1'b1;
      frame_irq = 1'b1;
      drive(3, 25000, 0);
      frame_irq = 1'b0;                         // limiting back on
      cascade_slave = 1'b1;
      drive(80, 25000, 0);
      one(-29999, "R8", -29999);
      cascade_slave = 1'b0;
      drive(80, 25000, 0);
      @(negedge clk);
      check_cycle();
      finish_run();
   end
endmodule